// File: doc/BRIEF.md
# Banked Operand Address Register

This block holds the operand address of a character-serial processor. During instruction extraction it takes an operand address whose width follows the addressing mode. A two-character address carries 12 bits, a three-character address carries 15 bits and a four-character address carries 19 bits. During execution the register steps by one for each character moved, either up or down. The whole register value is always the operand address. Upper bits that a short address leaves in place therefore act as a base: a bank in two-character mode, a sector in three-character mode.

In the short modes, a load or an internal step changes only the low part. That low part wraps without carrying into or borrowing from the retained upper bits. A load tagged as a full-register load writes every bit, whatever the mode. Stepping in four-character mode, or during a peripheral transfer, runs across all bits, so the address is continuous through memory. The number of implemented address bits is set by a parameter. Bits above that width read as zero.

Top module: `oper_addr_reg`

## Requirements
- R1: After a synchronous active-low reset the operand address output is zero.
- R2: A load with mode code 2'b00 (two-character) and the full-load flag low replaces bits [11:0] with the input address and keeps all higher bits. For example, upper bits 0x02000 combined with a loaded 0xFA0 present address 12192.
- R3: A load with mode code 2'b01 (three-character) and the full-load flag low replaces bits [14:0] and keeps all higher bits.
- R4: A load with mode code 2'b10 or 2'b11 (four-character) replaces every implemented bit.
- R5: A load with the full-load flag high replaces every implemented bit in any mode.
- R6: An internal step (peripheral flag low) in mode 2'b00 changes only bits [11:0]. These bits wrap from 0xFFF to 0x000 on increment and from 0x000 to 0xFFF on decrement, with no carry or borrow into bits above.
- R7: An internal step in mode 2'b01 changes only bits [14:0] and wraps within them.
- R8: A step in mode 2'b10 or 2'b11, or any step with the peripheral flag high, carries or borrows across all implemented bits and wraps at the top of the implemented width.
- R9: With the parameter ACT_W below 19, output bits at ACT_W and above always read zero, and writes to them have no effect.
- R10: When increment and decrement are both high with no load, the register holds its value.
- R11: A load in the same cycle as a step takes effect and the step is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load strobe for an extracted address |
| mode_i | input | 2 | Addressing mode: 00 two-char, 01 three-char, 10/11 four-char |
| full_ld_i | input | 1 | Load writes the whole register regardless of mode |
| addr_i | input | 19 | Address value to load |
| inc_i | input | 1 | Step up by one |
| dec_i | input | 1 | Step down by one |
| periph_i | input | 1 | High during a peripheral transfer, low during internal execution |
| oper_addr_o | output | 19 | Full register value used as operand address |

## Verification
Every result of this block is due one clock edge after its stimulus. A load, a step, a hold or a reset all show on the output right after the rising edge that samples them, because the register is the only storage between input and output. The bench changes inputs on the falling edge and samples 1 ns after the next rising edge. It then drops the strobes, so each check sees exactly one operation. A second instance with 16 implemented bits is checked only in the width scenario.

// File: rtl/oar_pkg.sv
// Package: shared addressing-mode type for the operand address register.
// Assumes the two-bit mode code is decoded identically by every submodule.
package oar_pkg;
    typedef enum logic [1:0] {
        AM_TWO      = 2'b00,
        AM_THREE    = 2'b01,
        AM_FOUR     = 2'b10,
        AM_FOUR_ALT = 2'b11
    } addr_mode_e;
endpackage

// File: rtl/oar_span_sel.sv
// Span selector: produces the bit masks that a load and a step may change.
// Assumes the low spans are contiguous from bit 0 and LOW2_W < LOW3_W <= ADDR_W.
module oar_span_sel
    import oar_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int ACT_W  = 19,
    parameter int LOW2_W = 12,
    parameter int LOW3_W = 15
) (
    input  addr_mode_e        mode,
    input  logic              full_ld,
    input  logic              periph,
    output logic [ADDR_W-1:0] load_mask,
    output logic [ADDR_W-1:0] step_mask
);
    localparam logic [ADDR_W-1:0] ACT_MASK = ADDR_W'((64'd1 << ACT_W) - 64'd1);
    localparam logic [ADDR_W-1:0] M_TWO    = ADDR_W'((64'd1 << LOW2_W) - 64'd1) & ACT_MASK;
    localparam logic [ADDR_W-1:0] M_THREE  = ADDR_W'((64'd1 << LOW3_W) - 64'd1) & ACT_MASK;

    logic [ADDR_W-1:0] mode_mask;

    // Purpose: span written by a short-mode load or internal step.
    always_comb begin
        unique case (mode)
            AM_TWO:   mode_mask = M_TWO;
            AM_THREE: mode_mask = M_THREE;
            default:  mode_mask = ACT_MASK;
        endcase
    end

    // Purpose: full-register load overrides the mode span.
    always_comb load_mask = full_ld ? ACT_MASK : mode_mask;

    // Purpose: peripheral transfers always step across the whole register.
    always_comb step_mask = periph ? ACT_MASK : mode_mask;
endmodule

// File: rtl/oar_load_merge.sv
// Load merge: writes the masked part of the new address, keeps the rest.
// Assumes the mask already excludes unimplemented bits.
module oar_load_merge #(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] merged
);
    // Purpose: bitwise select between old and loaded value.
    always_comb merged = (cur & ~mask) | (addr & mask);
endmodule

// File: rtl/oar_step_unit.sv
// Step unit: adds or subtracts one inside the masked low span, wrapping
// there and leaving bits outside the span untouched. Both or neither
// strobe gives no step. Assumes the mask is contiguous from bit 0.
module oar_step_unit #(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] mask,
    input  logic              inc,
    input  logic              dec,
    output logic              step_en,
    output logic [ADDR_W-1:0] stepped
);
    logic [ADDR_W-1:0] sum;

    // Purpose: one step is taken only when exactly one strobe is high.
    always_comb step_en = inc ^ dec;

    // Purpose: full-width add/subtract, then confine the change to the span.
    always_comb begin
        sum     = inc ? cur + ADDR_W'(1) : cur - ADDR_W'(1);
        stepped = (cur & ~mask) | (sum & mask);
    end
endmodule

// File: rtl/oper_addr_reg.sv
// Operand address register: holds the operand address with bank/sector
// retention for short addressing modes. Load wins over a step; both step
// strobes together hold. Assumes 12 <= ACT_W <= ADDR_W.
module oper_addr_reg
    import oar_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int ACT_W  = 19,
    parameter int LOW2_W = 12,
    parameter int LOW3_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [1:0]        mode_i,
    input  logic              full_ld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic              periph_i,
    output logic [ADDR_W-1:0] oper_addr_o
);
    localparam logic [ADDR_W-1:0] ACT_MASK = ADDR_W'((64'd1 << ACT_W) - 64'd1);

    addr_mode_e        mode;
    logic [ADDR_W-1:0] load_mask, step_mask, merged, stepped, q;
    logic              step_en;

    // Purpose: cast the raw mode code to the shared type.
    always_comb mode = addr_mode_e'(mode_i);

    oar_span_sel #(
        .ADDR_W(ADDR_W), .ACT_W(ACT_W), .LOW2_W(LOW2_W), .LOW3_W(LOW3_W)
    ) u_span (
        .mode(mode), .full_ld(full_ld_i), .periph(periph_i),
        .load_mask(load_mask), .step_mask(step_mask)
    );

    oar_load_merge #(.ADDR_W(ADDR_W)) u_load (
        .cur(q), .addr(addr_i), .mask(load_mask), .merged(merged)
    );

    oar_step_unit #(.ADDR_W(ADDR_W)) u_step (
        .cur(q), .mask(step_mask), .inc(inc_i), .dec(dec_i),
        .step_en(step_en), .stepped(stepped)
    );

    // Purpose: the address register with load-over-step priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_i)  q <= merged & ACT_MASK;
        else if (step_en) q <= stepped & ACT_MASK;
    end

    // Purpose: whole register is the operand address.
    always_comb oper_addr_o = q;

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oper_addr_o & ~ACT_MASK) == '0);

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !full_ld_i && mode_i == 2'b00 |=>
        oper_addr_o[LOW2_W-1:0] == $past(addr_i[LOW2_W-1:0]) &&
        oper_addr_o[ADDR_W-1:LOW2_W] == $past(oper_addr_o[ADDR_W-1:LOW2_W]));

    assert_full_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && full_ld_i |=> oper_addr_o == ($past(addr_i) & ACT_MASK));

    assert_bank_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && (inc_i ^ dec_i) && !periph_i && mode_i == 2'b00 |=>
        oper_addr_o[ADDR_W-1:LOW2_W] == $past(oper_addr_o[ADDR_W-1:LOW2_W]));

    assert_sector_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && (inc_i ^ dec_i) && !periph_i && mode_i == 2'b01 |=>
        oper_addr_o[ADDR_W-1:LOW3_W] == $past(oper_addr_o[ADDR_W-1:LOW3_W]));

    assert_both_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && inc_i && dec_i |=> $stable(oper_addr_o));
endmodule

// File: tb/tb_oper_addr_reg.sv
`timescale 1ns/1ps
module tb_oper_addr_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, full_ld_i = 1'b0, inc_i = 1'b0, dec_i = 1'b0, periph_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [18:0] addr_i = '0;
    logic [18:0] q, q16;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    oper_addr_reg dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode_i(mode_i),
        .full_ld_i(full_ld_i), .addr_i(addr_i), .inc_i(inc_i), .dec_i(dec_i),
        .periph_i(periph_i), .oper_addr_o(q)
    );

    oper_addr_reg #(.ACT_W(16)) dut16 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode_i(mode_i),
        .full_ld_i(full_ld_i), .addr_i(addr_i), .inc_i(inc_i), .dec_i(dec_i),
        .periph_i(periph_i), .oper_addr_o(q16)
    );

    task automatic chk(input string tag, input logic [18:0] got, input logic [18:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // One operation: drive on falling edge, sample 1 ns after the rising edge.
    task automatic op(input logic ld, input logic [1:0] md, input logic fl,
                      input logic [18:0] a, input logic in, input logic de, input logic pe);
        @(negedge clk);
        load_i = ld; mode_i = md; full_ld_i = fl; addr_i = a;
        inc_i = in; dec_i = de; periph_i = pe;
        @(posedge clk); #1;
        load_i = 0; full_ld_i = 0; inc_i = 0; dec_i = 0; periph_i = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk); #1;
        chk("R1 reset", q, 19'h00000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_four_load;
        op(1, 2'b10, 0, 19'h70ABC, 0, 0, 0); chk("R4 mode10", q, 19'h70ABC);
        op(1, 2'b11, 0, 19'h12345, 0, 0, 0); chk("R4 mode11", q, 19'h12345);
    endtask

    task automatic t_two_load;
        op(1, 2'b10, 0, 19'h02000, 0, 0, 0);
        op(1, 2'b00, 0, 19'h00FA0, 0, 0, 0); chk("R2 bank 12192", q, 19'd12192);
        op(1, 2'b10, 0, 19'h45123, 0, 0, 0);
        op(1, 2'b00, 0, 19'h3A456, 0, 0, 0); chk("R2 upper kept", q, 19'h45456);
    endtask

    task automatic t_three_load;
        op(1, 2'b10, 0, 19'h08000, 0, 0, 0);
        op(1, 2'b01, 0, 19'h7AEE0, 0, 0, 0); chk("R3 sector 44768", q, 19'd44768);
    endtask

    task automatic t_full_load;
        op(1, 2'b10, 0, 19'h7FFFF, 0, 0, 0);
        op(1, 2'b00, 1, 19'h00123, 0, 0, 0); chk("R5 two-char full", q, 19'h00123);
        op(1, 2'b01, 1, 19'h6F00D, 0, 0, 0); chk("R5 three-char full", q, 19'h6F00D);
    endtask

    task automatic t_two_step;
        op(1, 2'b10, 0, 19'h51FFF, 0, 0, 0);
        op(0, 2'b00, 0, '0, 1, 0, 0); chk("R6 inc wrap", q, 19'h51000);
        op(0, 2'b00, 0, '0, 0, 1, 0); chk("R6 dec wrap", q, 19'h51FFF);
    endtask

    task automatic t_three_step;
        op(1, 2'b10, 0, 19'h47FFF, 0, 0, 0);
        op(0, 2'b01, 0, '0, 1, 0, 0); chk("R7 inc wrap", q, 19'h40000);
        op(0, 2'b01, 0, '0, 0, 1, 0); chk("R7 dec wrap", q, 19'h47FFF);
    endtask

    task automatic t_cont_step;
        op(1, 2'b10, 0, 19'h51FFF, 0, 0, 0);
        op(0, 2'b00, 0, '0, 1, 0, 1); chk("R8 periph carry", q, 19'h52000);
        op(0, 2'b01, 0, '0, 0, 1, 1); chk("R8 periph borrow", q, 19'h51FFF);
        op(1, 2'b10, 0, 19'h47FFF, 0, 0, 0);
        op(0, 2'b10, 0, '0, 1, 0, 0); chk("R8 four carry", q, 19'h48000);
        op(1, 2'b10, 0, 19'h7FFFF, 0, 0, 0);
        op(0, 2'b11, 0, '0, 1, 0, 0); chk("R8 top wrap", q, 19'h00000);
        op(0, 2'b10, 0, '0, 0, 1, 0); chk("R8 bottom wrap", q, 19'h7FFFF);
    endtask

    task automatic t_both_hold;
        op(1, 2'b10, 0, 19'h33333, 0, 0, 0);
        op(0, 2'b10, 0, '0, 1, 1, 1); chk("R10 hold", q, 19'h33333);
    endtask

    task automatic t_load_prio;
        op(1, 2'b10, 0, 19'h10000, 1, 0, 0); chk("R11 load over inc", q, 19'h10000);
        op(1, 2'b00, 0, 19'h00000, 0, 1, 1); chk("R11 load over dec", q, 19'h10000);
    endtask

    task automatic t_width;
        op(1, 2'b10, 0, 19'h7FFFF, 0, 0, 0); chk("R9 narrow load", q16, 19'h0FFFF);
        op(0, 2'b10, 0, '0, 1, 0, 0);        chk("R9 narrow wrap", q16, 19'h00000);
        op(0, 2'b10, 0, '0, 0, 1, 1);        chk("R9 narrow borrow", q16, 19'h0FFFF);
    endtask

    initial begin
        t_reset;
        t_four_load;
        t_two_load;
        t_three_load;
        t_full_load;
        t_two_step;
        t_three_step;
        t_cont_step;
        t_both_hold;
        t_load_prio;
        t_width;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule